// File: doc/BRIEF.md
# Data Window Address Translator

This block turns a logical data address into a physical one. The logical data space is split into four equal windows of 0x4000 bytes. Each window has its own 16-bit mapping word. That word routes the window to one of four targets: unified memory, instruction memory, a segment of internal data memory, or an I/O area split into four sub-windows. Each request also carries a byte count. The block shortens that count so the access ends at the window edge at the latest.

A requester presents an address and a length with a valid strobe. One clock later the block returns the physical address, the clipped length and a fault flag. Unsupported cases come back as faults with zero length: an address past the last window, or a window set to the reserved space. A write port loads the four mapping words one at a time. After reset the words hold the internal-memory startup layout.

Top module: `data_window_xlate`

## Requirements
- R1: The window index is logical address bits [15:14] and the offset is bits [13:0]. Any address of 0x10000 or above returns fault=1, length 0 and physical address 0.
- R2: When offset + length exceeds 0x4000, the returned length is 0x4000 − offset. Otherwise the length is returned unchanged, including a length of zero.
- R3: When bit 15 of the window's mapping word is set, the result is 0x0200_0000 + nibble×0x10000 + 0xC000 + offset. Offset bits [13:12] pick the nibble: value 0 takes word bits [15:12], 1 takes [11:8], 2 takes [7:4] and 3 takes [3:0].
- R4: With bit 15 clear, word bits [13:12] pick the space and bits [9:0] give the segment. Bits 14, 11 and 10 are ignored. Space 00 gives seg×0x4000 + offset, with the unified base at 0.
- R5: Space 01 gives 0x0100_0000 + seg×0x4000 + offset.
- R6: Space 10 gives 0x0200_0000 + seg×0x10000 + window×0x4000 + offset.
- R7: Space 11 is reserved. It returns fault=1, length 0 and physical address 0.
- R8: After reset, windows 0, 1 and 2 hold 0x2000 and window 3 holds 0x0000.
- R9: Each request produces exactly one response, with the valid flag set on the clock after the request. No response appears without a request, and none appears during reset.
- R10: A mapping write (select = window number) applies to requests from the next cycle on. A request in the same cycle as the write still uses the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | LA_W (18) | Logical address |
| req_len | input | LEN_W (16) | Requested byte count |
| map_we | input | 1 | Mapping word write enable |
| map_sel | input | 2 | Window whose word is written |
| map_wdata | input | 16 | New mapping word |
| rsp_valid | output | 1 | Response strobe |
| rsp_addr | output | PA_W (32) | Physical address |
| rsp_len | output | LEN_W (16) | Clipped byte count |
| rsp_fault | output | 1 | Unsupported access |

## Verification
The bench uses the default parameters: an 18-bit logical address, 0x4000-byte windows and a 16-bit length. Because the address input is two bits wider than the four windows need, addresses past the last window can be driven directly. The 16-bit length reaches well beyond one window, so the clip is tested both at its edge and far past it. The default bases let each space be recognised in the returned address by its top byte.

// File: rtl/dwt_pkg.sv
// Shared constants for the data window translator.
// Assumes a 16-bit mapping word with the field positions listed below.
package dwt_pkg;
    localparam int MAP_W    = 16;
    localparam int IO_BIT   = 15;
    localparam int SPACE_LO = 12;
    localparam int SEG_W    = 10;
    localparam int NIB_W    = 4;

    typedef enum logic [1:0] {
        SP_UNIFIED = 2'b00,
        SP_INSN    = 2'b01,
        SP_DATA    = 2'b10,
        SP_RSVD    = 2'b11
    } space_e;
endpackage

// File: rtl/dwt_map_regs.sv
// Holds the per-window mapping words.
// Assumes: one write per cycle, and a combinational read that returns the
// value from before any write in the same cycle.
module dwt_map_regs
    import dwt_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int IDX_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] wsel,
    input  logic [MAP_W-1:0] wdata,
    input  logic [IDX_W-1:0] rsel,
    output logic [MAP_W-1:0] rdata
);
    logic [MAP_W-1:0] map_q [NUM_WIN];

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [MAP_W-1:0] RST_VAL = (i == NUM_WIN - 1) ? 16'h0000 : 16'h2000;
        // Load the startup layout on reset, else take the selected write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                map_q[i] <= RST_VAL;
            else if (we && wsel == IDX_W'(i))
                map_q[i] <= wdata;
        end
    end

    // Read port sees the registered word.
    always_comb rdata = map_q[rsel];

    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (map_q[$past(wsel)] == $past(wdata)));
endmodule

// File: rtl/dwt_clip.sv
// Shortens a byte count so the access does not pass the window end.
// Assumes LEN_W > WOFF_W so the room left in a window fits in the count.
module dwt_clip #(
    parameter int WOFF_W = 14,
    parameter int LEN_W  = 16
) (
    input  logic [WOFF_W-1:0] offset,
    input  logic [LEN_W-1:0]  len_in,
    output logic [LEN_W-1:0]  len_out
);
    localparam int SUM_W = ((LEN_W > WOFF_W) ? LEN_W : WOFF_W) + 1;
    localparam logic [SUM_W-1:0] WSIZE = SUM_W'(1) << WOFF_W;

    logic [SUM_W-1:0] end_pos;
    logic [SUM_W-1:0] room;

    // Compare the access end to the window size and clip if it lies past it.
    always_comb begin
        end_pos = SUM_W'(offset) + SUM_W'(len_in);
        room    = WSIZE - SUM_W'(offset);
        len_out = (end_pos > WSIZE) ? LEN_W'(room) : len_in;
    end
endmodule

// File: rtl/dwt_xlate.sv
// Maps a window index, an offset and a mapping word to a physical address.
// Assumes WOFF_W >= 14, so offset bits [13:12] exist for I/O sub-windows.
module dwt_xlate
    import dwt_pkg::*;
#(
    parameter int          IDX_W     = 2,
    parameter int          WOFF_W    = 14,
    parameter int          PA_W      = 32,
    parameter logic [31:0] UNI_BASE  = 32'h0000_0000,
    parameter logic [31:0] INSN_BASE = 32'h0100_0000,
    parameter logic [31:0] DATA_BASE = 32'h0200_0000
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic [WOFF_W-1:0] offset,
    input  logic [MAP_W-1:0]  map,
    output logic [PA_W-1:0]   phys,
    output logic              fault
);
    localparam logic [PA_W-1:0] IO_AREA = PA_W'(32'h0000_C000);

    space_e           space;
    logic [SEG_W-1:0] seg;
    logic [1:0]       sub;
    logic [NIB_W-1:0] nib;
    logic             unused_map_bits;

    assign unused_map_bits = ^{map[14], map[11:10]};

    // Decode fields and pick the I/O nibble, most significant first.
    always_comb begin
        space = space_e'(map[SPACE_LO +: 2]);
        seg   = map[SEG_W-1:0];
        sub   = 2'(offset >> 12);
        case (sub)
            2'd0:    nib = map[15:12];
            2'd1:    nib = map[11:8];
            2'd2:    nib = map[7:4];
            default: nib = map[3:0];
        endcase
    end

    // Form the physical address for the selected space.
    always_comb begin
        fault = 1'b0;
        phys  = '0;
        if (map[IO_BIT]) begin
            phys = PA_W'(DATA_BASE) + (PA_W'(nib) << 16) + IO_AREA + PA_W'(offset);
        end else begin
            case (space)
                SP_UNIFIED: phys = PA_W'(UNI_BASE) + (PA_W'(seg) << WOFF_W) + PA_W'(offset);
                SP_INSN:    phys = PA_W'(INSN_BASE) + (PA_W'(seg) << WOFF_W) + PA_W'(offset);
                SP_DATA:    phys = PA_W'(DATA_BASE) + (PA_W'(seg) << 16)
                                 + (PA_W'(idx) << WOFF_W) + PA_W'(offset);
                default:    fault = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/data_window_xlate.sv
// Top of the data window translator: splits the logical address, looks up
// the window's mapping word, translates and clips, and registers the result.
// Assumes NUM_WIN is a power of two and LA_W > WOFF_W + log2(NUM_WIN).
module data_window_xlate
    import dwt_pkg::*;
#(
    parameter int LA_W    = 18,
    parameter int WOFF_W  = 14,
    parameter int NUM_WIN = 4,
    parameter int LEN_W   = 16,
    parameter int PA_W    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [LA_W-1:0]  req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic             map_we,
    input  logic [1:0]       map_sel,
    input  logic [15:0]      map_wdata,
    output logic             rsp_valid,
    output logic [PA_W-1:0]  rsp_addr,
    output logic [LEN_W-1:0] rsp_len,
    output logic             rsp_fault
);
    localparam int IDX_W = $clog2(NUM_WIN);
    localparam int HI_LO = WOFF_W + IDX_W;
    localparam int SUM_W = ((LEN_W > WOFF_W) ? LEN_W : WOFF_W) + 1;

    logic [IDX_W-1:0]  win_idx;
    logic [WOFF_W-1:0] win_off;
    logic              out_of_range;
    logic [MAP_W-1:0]  map_word;
    logic [PA_W-1:0]   xl_phys;
    logic              xl_fault;
    logic [LEN_W-1:0]  clip_len;
    logic              any_fault;

    // Split the logical address and flag addresses past the last window.
    always_comb begin
        win_idx      = req_addr[WOFF_W +: IDX_W];
        win_off      = req_addr[WOFF_W-1:0];
        out_of_range = |req_addr[LA_W-1:HI_LO];
        any_fault    = out_of_range | xl_fault;
    end

    dwt_map_regs #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(map_we), .wsel(IDX_W'(map_sel)),
        .wdata(map_wdata), .rsel(win_idx), .rdata(map_word)
    );

    dwt_xlate #(.IDX_W(IDX_W), .WOFF_W(WOFF_W), .PA_W(PA_W)) u_xlate (
        .idx(win_idx), .offset(win_off), .map(map_word),
        .phys(xl_phys), .fault(xl_fault)
    );

    dwt_clip #(.WOFF_W(WOFF_W), .LEN_W(LEN_W)) u_clip (
        .offset(win_off), .len_in(req_len), .len_out(clip_len)
    );

    // Register the response; faults return zero address and zero length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            rsp_len   <= '0;
            rsp_fault <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault <= any_fault;
                rsp_addr  <= any_fault ? '0 : xl_phys;
                rsp_len   <= any_fault ? '0 : clip_len;
            end
        end
    end

    p_resp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_stray_resp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));
    p_fault_no_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_len == '0 && rsp_addr == '0));
    p_range_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && out_of_range) |=> rsp_fault);
    p_reserved_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !map_word[IO_BIT] && map_word[13:12] == 2'b11) |=> rsp_fault);
    p_no_crossing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |->
        (SUM_W'($past(win_off)) + SUM_W'(rsp_len) <= (SUM_W'(1) << WOFF_W)));
endmodule

// File: tb/data_window_xlate_test.sv
// Scoreboard bench: the driver pushes model results, the monitor compares them.
module data_window_xlate_test;
    localparam int LA_W = 18, LEN_W = 16, PA_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic [LA_W-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic map_we = 1'b0;
    logic [1:0] map_sel = '0;
    logic [15:0] map_wdata = '0;
    logic rsp_valid;
    logic [PA_W-1:0] rsp_addr;
    logic [LEN_W-1:0] rsp_len;
    logic rsp_fault;

    always #10 clk = ~clk;

    data_window_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .map_we(map_we), .map_sel(map_sel), .map_wdata(map_wdata),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_len(rsp_len), .rsp_fault(rsp_fault)
    );

    typedef struct {
        logic [31:0] phys;
        int          len;
        bit          fault;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [15:0] shadow [4] = '{16'h2000, 16'h2000, 16'h2000, 16'h0000};

    function automatic exp_t model(int a, int l, string tag);
        exp_t e;
        int idx, off, m, sub, nib, sp, seg;
        e.tag = tag; e.phys = '0; e.len = 0; e.fault = 1'b0;
        if (a >= 4 * 16384) begin
            e.fault = 1'b1;
            return e;
        end
        idx = a / 16384;
        off = a % 16384;
        e.len = (off + l > 16384) ? 16384 - off : l;
        m = int'(shadow[idx]);
        if (m >= 32768) begin
            sub = (off / 4096) % 4;
            nib = (m >> (4 * (3 - sub))) % 16;
            e.phys = 32'(32'h0200_0000 + nib * 65536 + 49152 + off);
        end else begin
            sp  = (m / 4096) % 4;
            seg = m % 1024;
            case (sp)
                0: e.phys = 32'(seg * 16384 + off);
                1: e.phys = 32'(32'h0100_0000 + seg * 16384 + off);
                2: e.phys = 32'(32'h0200_0000 + seg * 65536 + idx * 16384 + off);
                default: begin e.fault = 1'b1; e.len = 0; end
            endcase
        end
        return e;
    endfunction

    task automatic step(bit rq, int a, int l, bit wr, int sel, logic [15:0] d, string tag);
        @(negedge clk);
        req_valid = rq; req_addr = LA_W'(a); req_len = LEN_W'(l);
        map_we = wr; map_sel = 2'(sel); map_wdata = d;
        if (rq) sbq.push_back(model(a, l, tag));
        if (wr) shadow[sel] = d;
    endtask

    task automatic req(int a, int l, string tag);
        step(1'b1, a, l, 1'b0, 0, 16'h0, tag);
    endtask

    task automatic wr(int sel, logic [15:0] d);
        step(1'b0, 0, 0, 1'b1, sel, d, "");
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 0, 16'h0, "");
    endtask

    // Monitor: pop and compare each response as it appears.
    always @(negedge clk) begin
        if (rst_n && !done && rsp_valid === 1'b1) begin
            n_cmp++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL R9: response without request, actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (rsp_addr !== e.phys || int'(rsp_len) != e.len || rsp_fault !== e.fault) begin
                    n_bad++;
                    $display("FAIL %s: actual addr=%h len=%0d fault=%0b expected addr=%h len=%0d fault=%0b",
                             e.tag, rsp_addr, rsp_len, rsp_fault, e.phys, e.len, e.fault);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        n_cmp++;
        if (rsp_valid !== 1'b0) begin
            n_bad++;
            $display("FAIL R9: after reset actual valid=%0b expected 0", rsp_valid);
        end
        // R8: startup layout in each window
        req(32'h0000, 2, "R8"); req(32'h4000, 2, "R8");
        req(32'h8000, 2, "R8"); req(32'hC010, 2, "R8");
        // R4: unified space, including ignored word bits
        wr(0, 16'h0005); req(32'h0123, 4, "R4");
        wr(0, 16'h4FFF); req(32'h3F00, 8, "R4");
        // R5: instruction space
        wr(1, 16'h1007); req(32'h4010, 6, "R5");
        // R6: internal data space uses the window index
        wr(2, 16'h2003); req(32'h8100, 2, "R6"); req(32'hBFFE, 2, "R6");
        // R7: reserved space
        wr(3, 16'h3000); req(32'hC000, 4, "R7"); req(32'hFFFF, 1, "R7");
        // R3: I/O sub-windows, one per nibble
        wr(0, 16'h9ABC);
        req(32'h0000, 2, "R3"); req(32'h1000, 2, "R3");
        req(32'h2004, 2, "R3"); req(32'h3FFF, 1, "R3");
        // R2: clipping at and past the window end
        wr(1, 16'h1002);
        req(32'h7FF0, 32'h20, "R2"); req(32'h7FF0, 32'h10, "R2");
        req(32'h4000, 32'hFFFF, "R2"); req(32'h5000, 0, "R2");
        // R1: window split edge and addresses past the last window
        req(32'h3FFF, 2, "R1"); req(32'h10000, 4, "R1"); req(32'h3FFFF, 4, "R1");
        // R10: write and request in the same cycle, then after
        step(1'b1, 32'h8010, 4, 1'b1, 2, 16'h1001, "R10");
        req(32'h8010, 4, "R10");
        // R9: gaps between requests must stay silent
        idle(); idle(); req(32'h4000, 1, "R9"); idle(); idle(); idle();
        n_cmp++;
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL R9: actual %0d responses missing expected 0", sbq.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R9: watchdog expired, actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule